// File: doc/BRIEF.md
# Exception Entry and Vector Sequencer

This block takes one pending exception per strobe and, on the next clock edge, produces the state a processor core needs to enter the handler. It produces the saved return address for the path that applies, the rewritten status, cause and debug control words, and the address of the first handler instruction. Three entry paths exist. The general path serves ordinary faults, TLB misses and interrupts. The error path serves hard reset, soft reset and the non-maskable interrupt. The debug path serves the debug-class events. Each path has its own return-address register and its own rules for the vector.

The core presents the current program counter, a flag telling whether the faulting instruction sits in a branch delay slot, the live status and cause words, the debug control word, the exception base register, a refill qualifier for TLB misses and the debug-mode flag. A fault in a delay slot records the address of the branch, which is PC minus 4, so that the branch runs again on return. The `taken_o` pulse tells the core to load `next_pc_o`. The same pulse tells the core to force kernel mode and clear its delay-slot flag. The rewritten status, cause and debug words stay on the outputs until the next strobe, so the core's register file can capture them.

Top module: `exc_entry_seq`

## Requirements
- R1: `exc_kind_i` codes: 0 general, 1 TLB miss, 2 interrupt, 3 hard reset, 4 soft reset, 5 NMI, 6 debug single step, 7 debug interrupt, 8 debug instruction break, 9 debug breakpoint, 10 debug data-store break, 11 debug data-load break. A strobe on `exc_valid_i` gives a single-cycle `taken_o` and all results after exactly one clock edge. With no strobe, every result output holds its value. After reset, all outputs are zero.
- R2: On a general-path entry with status bit 1 (EXL) clear, EPC takes PC and cause bit 31 (BD) is cleared. If the delay-slot flag is set, EPC takes PC-4 and BD is set instead.
- R3: On a general-path entry with EXL already set, EPC and cause bit 31 keep their previous values.
- R4: A general-path entry sets EXL and writes `exc_code_i` into cause bits 6:2. All other status and cause bits pass through unchanged.
- R5: The vector base is 0xBFC00200 when status bit 22 (BEV) is set. Otherwise it is the base register with bits 9:0 cleared. A general fault adds 0x180 to the base.
- R6: A TLB miss adds offset 0x000 only when `tlb_refill_i` is set and EXL is clear. In every other case it adds 0x180.
- R7: An interrupt outside debug mode adds 0x200 when cause bit 23 (IV) is set, and 0x180 otherwise.
- R8: Hard reset, soft reset and NMI save PC, or PC-4 in a delay slot, into ErrorEPC. They set status bits 2 (ERL) and 22 (BEV), and jump to 0xBFC00000. Soft reset also sets status bit 20, and NMI also sets status bit 19. BD is cleared only when EXL is clear, and EPC is untouched.
- R9: Debug kinds set one debug-word bit each: single step bit 0, breakpoint bit 1, data-load break bit 2, data-store break bit 3, instruction break bit 4, debug interrupt bit 5. They save PC, or PC-4 in a delay slot, into DEPC. Single step always saves PC. The entry pulses `enter_debug_o` and jumps to 0xBFC00480. BD is cleared only when EXL is clear.
- R10: An interrupt strobed while `debug_mode_i` is set is handled as a debug interrupt: it sets debug bit 5, takes the debug vector and leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid_i | input | 1 | Exception strobe |
| exc_kind_i | input | 4 | Exception kind code |
| exc_code_i | input | 5 | Cause code for general-path entries |
| pc_i | input | AW | Program counter of the faulting instruction |
| in_delay_slot_i | input | 1 | Fault is in a branch delay slot |
| status_i | input | RW | Current status word |
| cause_i | input | RW | Current cause word |
| debug_i | input | RW | Current debug control word |
| ebase_i | input | AW | Exception base register |
| tlb_refill_i | input | 1 | TLB miss qualifies for the refill vector |
| debug_mode_i | input | 1 | Core is in debug mode |
| taken_o | output | 1 | Entry pulse: load PC, force kernel, clear delay-slot flag |
| next_pc_o | output | AW | Handler address |
| enter_debug_o | output | 1 | Entry pulse for the debug path |
| status_o | output | RW | Rewritten status word |
| cause_o | output | RW | Rewritten cause word |
| debug_o | output | RW | Rewritten debug control word |
| epc_o | output | AW | General-path return address |
| error_epc_o | output | AW | Error-path return address |
| depc_o | output | AW | Debug-path return address |

## Verification
The bench uses the default 32-bit address width and the default vector constants. Every handler address can therefore be compared against the fixed boot, reset and debug addresses, and the random base registers exercise the clearing of bits 9:0. Random status and cause words make EXL, BEV and IV toggle freely, so every pairing of an entry path with the EXL state occurs. Directed cases force the refill qualifier with and without EXL, delay-slot single steps, and interrupts during debug mode.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int KIND_W = 4;
  localparam int CODE_W = 5;
  localparam int DBG_W  = 6;

  // Status word bit positions decoded by the core
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_NMI = 19;
  localparam int ST_SR  = 20;
  localparam int ST_BEV = 22;
  // Cause word bit positions
  localparam int CA_CODE_LSB = 2;
  localparam int CA_IV = 23;
  localparam int CA_BD = 31;
  // Debug word bit positions
  localparam int DB_STEP  = 0;
  localparam int DB_BRK   = 1;
  localparam int DB_DLOAD = 2;
  localparam int DB_DSTOR = 3;
  localparam int DB_IBRK  = 4;
  localparam int DB_INT   = 5;

  typedef enum logic [KIND_W-1:0] {
    EK_GENERAL    = 4'd0,
    EK_TLB_MISS   = 4'd1,
    EK_INTERRUPT  = 4'd2,
    EK_HARD_RESET = 4'd3,
    EK_SOFT_RESET = 4'd4,
    EK_NMI        = 4'd5,
    EK_DBG_STEP   = 4'd6,
    EK_DBG_INT    = 4'd7,
    EK_DBG_IBRK   = 4'd8,
    EK_DBG_BRK    = 4'd9,
    EK_DBG_DSTOR  = 4'd10,
    EK_DBG_DLOAD  = 4'd11
  } exc_kind_e;

  typedef enum logic [1:0] {
    PATH_GENERAL = 2'd0,
    PATH_ERROR   = 2'd1,
    PATH_DEBUG   = 2'd2
  } exc_path_e;

  typedef enum logic [1:0] {
    OFS_REFILL  = 2'd0,
    OFS_GENERAL = 2'd1,
    OFS_IRQ     = 2'd2
  } exc_ofs_e;

  typedef struct packed {
    exc_path_e          path;
    exc_ofs_e           ofs;
    logic [DBG_W-1:0]   dbg_set;
    logic               sr_set;
    logic               nmi_set;
    logic               plain_pc;
  } exc_class_t;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_seq_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic              debug_mode_i,
  input  logic              exl_i,
  input  logic              refill_i,
  input  logic              iv_i,
  output exc_class_t        class_o
);

  always_comb begin
    class_o      = '0;
    class_o.path = PATH_GENERAL;
    class_o.ofs  = OFS_GENERAL;
    case (exc_kind_e'(kind_i))
      EK_TLB_MISS: begin
        class_o.ofs = (refill_i && !exl_i) ? OFS_REFILL : OFS_GENERAL;
      end
      EK_INTERRUPT: begin
        if (debug_mode_i) begin
          class_o.path            = PATH_DEBUG;
          class_o.dbg_set[DB_INT] = 1'b1;
        end else begin
          class_o.ofs = iv_i ? OFS_IRQ : OFS_GENERAL;
        end
      end
      EK_HARD_RESET: class_o.path = PATH_ERROR;
      EK_SOFT_RESET: begin
        class_o.path   = PATH_ERROR;
        class_o.sr_set = 1'b1;
      end
      EK_NMI: begin
        class_o.path    = PATH_ERROR;
        class_o.nmi_set = 1'b1;
      end
      EK_DBG_STEP: begin
        class_o.path             = PATH_DEBUG;
        class_o.dbg_set[DB_STEP] = 1'b1;
        class_o.plain_pc         = 1'b1;
      end
      EK_DBG_INT: begin
        class_o.path            = PATH_DEBUG;
        class_o.dbg_set[DB_INT] = 1'b1;
      end
      EK_DBG_IBRK: begin
        class_o.path             = PATH_DEBUG;
        class_o.dbg_set[DB_IBRK] = 1'b1;
      end
      EK_DBG_BRK: begin
        class_o.path            = PATH_DEBUG;
        class_o.dbg_set[DB_BRK] = 1'b1;
      end
      EK_DBG_DSTOR: begin
        class_o.path              = PATH_DEBUG;
        class_o.dbg_set[DB_DSTOR] = 1'b1;
      end
      EK_DBG_DLOAD: begin
        class_o.path              = PATH_DEBUG;
        class_o.dbg_set[DB_DLOAD] = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_restart_pc.sv
module exc_restart_pc #(
  parameter int AW      = 32,
  parameter int DS_STEP = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic          in_delay_slot_i,
  input  logic          plain_i,
  output logic [AW-1:0] restart_o
);

  localparam logic [AW-1:0] STEP = AW'(DS_STEP);

  always_comb begin
    if (in_delay_slot_i && !plain_i) restart_o = pc_i - STEP;
    else                             restart_o = pc_i;
  end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_seq_pkg::*;
#(
  parameter int            AW          = 32,
  parameter int            BASE_ALIGN  = 10,
  parameter logic [AW-1:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [AW-1:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [AW-1:0] DEBUG_VEC   = 32'hBFC0_0480,
  parameter logic [AW-1:0] OFS_REFILL_V  = 32'h0000_0000,
  parameter logic [AW-1:0] OFS_GENERAL_V = 32'h0000_0180,
  parameter logic [AW-1:0] OFS_IRQ_V     = 32'h0000_0200
) (
  input  exc_path_e     path_i,
  input  exc_ofs_e      ofs_i,
  input  logic          bev_i,
  input  logic [AW-1:0] ebase_i,
  output logic [AW-1:0] pc_o
);

  localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << BASE_ALIGN) - AW'(1));

  logic [AW-1:0] base;
  logic [AW-1:0] offset;

  always_comb begin
    base = bev_i ? BOOT_BASE : (ebase_i & ALIGN_MASK);
    case (ofs_i)
      OFS_REFILL: offset = OFS_REFILL_V;
      OFS_IRQ:    offset = OFS_IRQ_V;
      default:    offset = OFS_GENERAL_V;
    endcase
    case (path_i)
      PATH_ERROR: pc_o = RESET_VEC;
      PATH_DEBUG: pc_o = DEBUG_VEC;
      default:    pc_o = base + offset;
    endcase
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            RW        = 32,
  parameter int            DS_STEP   = 4,
  parameter logic [AW-1:0] BOOT_BASE = 32'hBFC0_0200,
  parameter logic [AW-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [AW-1:0] DEBUG_VEC = 32'hBFC0_0480
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid_i,
  input  logic [KIND_W-1:0] exc_kind_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              in_delay_slot_i,
  input  logic [RW-1:0]     status_i,
  input  logic [RW-1:0]     cause_i,
  input  logic [RW-1:0]     debug_i,
  input  logic [AW-1:0]     ebase_i,
  input  logic              tlb_refill_i,
  input  logic              debug_mode_i,
  output logic              taken_o,
  output logic [AW-1:0]     next_pc_o,
  output logic              enter_debug_o,
  output logic [RW-1:0]     status_o,
  output logic [RW-1:0]     cause_o,
  output logic [RW-1:0]     debug_o,
  output logic [AW-1:0]     epc_o,
  output logic [AW-1:0]     error_epc_o,
  output logic [AW-1:0]     depc_o
);

  exc_class_t    cls;
  logic [AW-1:0] restart_pc;
  logic [AW-1:0] vec_pc;
  logic          exl;

  assign exl = status_i[ST_EXL];

  exc_classify u_classify (
    .kind_i       (exc_kind_i),
    .debug_mode_i (debug_mode_i),
    .exl_i        (exl),
    .refill_i     (tlb_refill_i),
    .iv_i         (cause_i[CA_IV]),
    .class_o      (cls)
  );

  exc_restart_pc #(.AW(AW), .DS_STEP(DS_STEP)) u_restart (
    .pc_i            (pc_i),
    .in_delay_slot_i (in_delay_slot_i),
    .plain_i         (cls.plain_pc),
    .restart_o       (restart_pc)
  );

  exc_vector #(
    .AW        (AW),
    .BOOT_BASE (BOOT_BASE),
    .RESET_VEC (RESET_VEC),
    .DEBUG_VEC (DEBUG_VEC)
  ) u_vector (
    .path_i  (cls.path),
    .ofs_i   (cls.ofs),
    .bev_i   (status_i[ST_BEV]),
    .ebase_i (ebase_i),
    .pc_o    (vec_pc)
  );

  // Next-state values
  logic [AW-1:0] epc_d, eepc_d, depc_d, npc_d;
  logic [RW-1:0] status_d, cause_d, debug_d;
  logic          dbg_d;

  always_comb begin
    epc_d    = epc_o;
    eepc_d   = error_epc_o;
    depc_d   = depc_o;
    npc_d    = vec_pc;
    status_d = status_i;
    cause_d  = cause_i;
    debug_d  = debug_i;
    dbg_d    = 1'b0;
    case (cls.path)
      PATH_ERROR: begin
        eepc_d           = restart_pc;
        status_d[ST_ERL] = 1'b1;
        status_d[ST_BEV] = 1'b1;
        if (cls.sr_set)  status_d[ST_SR]  = 1'b1;
        if (cls.nmi_set) status_d[ST_NMI] = 1'b1;
        if (!exl)        cause_d[CA_BD]   = 1'b0;
      end
      PATH_DEBUG: begin
        depc_d  = restart_pc;
        debug_d = debug_i | RW'(cls.dbg_set);
        dbg_d   = 1'b1;
        if (!exl) cause_d[CA_BD] = 1'b0;
      end
      default: begin
        if (!exl) begin
          epc_d          = restart_pc;
          cause_d[CA_BD] = in_delay_slot_i;
        end
        status_d[ST_EXL] = 1'b1;
        cause_d[CA_CODE_LSB +: CODE_W] = exc_code_i;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_o       <= 1'b0;
      enter_debug_o <= 1'b0;
    end else begin
      taken_o       <= exc_valid_i;
      enter_debug_o <= exc_valid_i & dbg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_pc_o   <= '0;
      status_o    <= '0;
      cause_o     <= '0;
      debug_o     <= '0;
      epc_o       <= '0;
      error_epc_o <= '0;
      depc_o      <= '0;
    end else if (exc_valid_i) begin
      next_pc_o   <= npc_d;
      status_o    <= status_d;
      cause_o     <= cause_d;
      debug_o     <= debug_d;
      epc_o       <= epc_d;
      error_epc_o <= eepc_d;
      depc_o      <= depc_d;
    end
  end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            RW        = 32,
  parameter logic [AW-1:0] RESET_VEC = 32'hBFC0_0000,
  parameter logic [AW-1:0] DEBUG_VEC = 32'hBFC0_0480
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_valid_i,
  input logic [KIND_W-1:0] exc_kind_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic [RW-1:0]     status_i,
  input logic [RW-1:0]     cause_i,
  input logic              debug_mode_i,
  input logic              taken_o,
  input logic [AW-1:0]     next_pc_o,
  input logic              enter_debug_o,
  input logic [RW-1:0]     status_o,
  input logic [RW-1:0]     cause_o,
  input logic [AW-1:0]     epc_o,
  input logic [AW-1:0]     error_epc_o,
  input logic [AW-1:0]     depc_o
);

  logic is_general, is_error, is_debug;
  assign is_error   = (exc_kind_i >= 4'd3) && (exc_kind_i <= 4'd5);
  assign is_debug   = ((exc_kind_i >= 4'd6) && (exc_kind_i <= 4'd11)) ||
                      ((exc_kind_i == 4'd2) && debug_mode_i);
  assign is_general = !is_error && !is_debug;

  p_taken_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid_i |=> taken_o);

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid_i |=> (!taken_o && $stable(epc_o) && $stable(error_epc_o) &&
                      $stable(depc_o) && $stable(next_pc_o)));

  p_exl_keeps_epc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && is_general && status_i[ST_EXL]) |=>
      ($stable(epc_o) && cause_o[CA_BD] == $past(cause_i[CA_BD])));

  p_general_sets_exl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && is_general) |=>
      (status_o[ST_EXL] && cause_o[CA_CODE_LSB +: CODE_W] == $past(exc_code_i)));

  p_error_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && is_error) |=>
      (next_pc_o == RESET_VEC && status_o[ST_ERL] && status_o[ST_BEV] && $stable(epc_o)));

  p_debug_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && is_debug) |=> (next_pc_o == DEBUG_VEC && enter_debug_o));

  p_irq_in_debug_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && exc_kind_i == 4'd2 && debug_mode_i) |=>
      (status_o == $past(status_i) && $stable(epc_o)));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .AW(AW), .RW(RW), .RESET_VEC(RESET_VEC), .DEBUG_VEC(DEBUG_VEC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .exc_valid_i   (exc_valid_i),
  .exc_kind_i    (exc_kind_i),
  .exc_code_i    (exc_code_i),
  .status_i      (status_i),
  .cause_i       (cause_i),
  .debug_mode_i  (debug_mode_i),
  .taken_o       (taken_o),
  .next_pc_o     (next_pc_o),
  .enter_debug_o (enter_debug_o),
  .status_o      (status_o),
  .cause_o       (cause_o),
  .epc_o         (epc_o),
  .error_epc_o   (error_epc_o),
  .depc_o        (depc_o)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [3:0]  kind;
  logic [4:0]  code;
  logic [31:0] pc, status, cause, dbg, ebase;
  logic        ds, refill, dmode;

  logic        taken, enter_dbg;
  logic [31:0] npc, st_o, ca_o, db_o, epc, eepc, depc;

  int n_cmp = 0;
  int n_bad = 0;

  // model state
  logic [31:0] m_epc = 0, m_eepc = 0, m_depc = 0;

  always #4 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .exc_valid_i(valid), .exc_kind_i(kind),
    .exc_code_i(code), .pc_i(pc), .in_delay_slot_i(ds), .status_i(status),
    .cause_i(cause), .debug_i(dbg), .ebase_i(ebase), .tlb_refill_i(refill),
    .debug_mode_i(dmode), .taken_o(taken), .next_pc_o(npc),
    .enter_debug_o(enter_dbg), .status_o(st_o), .cause_o(ca_o), .debug_o(db_o),
    .epc_o(epc), .error_epc_o(eepc), .depc_o(depc)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] k, input logic [4:0] c, input logic [31:0] p,
                      input logic d, input logic [31:0] s, input logic [31:0] ca,
                      input logic [31:0] db, input logic [31:0] eb,
                      input logic rf, input logic dm);
    logic [31:0] e_st, e_ca, e_db, e_npc, base, saved, ofs;
    logic        e_dbg, exl, is_dbg, is_err;
    string       vreq;
    @(negedge clk);
    valid = 1'b1; kind = k; code = c; pc = p; ds = d; status = s; cause = ca;
    dbg = db; ebase = eb; refill = rf; dmode = dm;
    exl    = s[1];
    is_dbg = (k >= 6 && k <= 11) || (k == 2 && dm);
    is_err = (k >= 3 && k <= 5);
    saved  = d ? p - 32'd4 : p;
    e_st = s; e_ca = ca; e_db = db; e_dbg = 1'b0;
    if (is_err) begin
      m_eepc = saved;
      e_st[2] = 1'b1; e_st[22] = 1'b1;
      if (k == 4) e_st[20] = 1'b1;
      if (k == 5) e_st[19] = 1'b1;
      if (!exl) e_ca[31] = 1'b0;
      e_npc = 32'hBFC0_0000; vreq = "R8";
    end else if (is_dbg) begin
      m_depc = (k == 6) ? p : saved;
      case (k)
        4'd6:  e_db[0] = 1'b1;
        4'd9:  e_db[1] = 1'b1;
        4'd11: e_db[2] = 1'b1;
        4'd10: e_db[3] = 1'b1;
        4'd8:  e_db[4] = 1'b1;
        default: e_db[5] = 1'b1;
      endcase
      if (!exl) e_ca[31] = 1'b0;
      e_dbg = 1'b1; e_npc = 32'hBFC0_0480;
      vreq = (k == 2) ? "R10" : "R9";
    end else begin
      if (!exl) begin m_epc = saved; e_ca[31] = d; end
      e_st[1] = 1'b1;
      e_ca[6:2] = c;
      base = s[22] ? 32'hBFC0_0200 : (eb & 32'hFFFF_FC00);
      ofs  = 32'h180; vreq = "R5";
      if (k == 1) begin vreq = "R6"; if (rf && !exl) ofs = 32'h0; end
      if (k == 2) begin vreq = "R7"; if (ca[23]) ofs = 32'h200; end
      e_npc = base + ofs;
    end
    @(negedge clk);
    valid = 1'b0;
    chk("R1", "taken", {31'd0, taken}, 32'd1);
    chk(vreq, "next_pc", npc, e_npc);
    chk(is_err ? "R8" : (is_dbg ? vreq : "R4"), "status", st_o, e_st);
    chk(is_dbg ? vreq : (exl ? "R3" : "R2"), "cause", ca_o, e_ca);
    chk(is_dbg ? vreq : "R9", "debug", db_o, e_db);
    chk("R9", "enter_debug", {31'd0, enter_dbg}, {31'd0, e_dbg});
    chk(exl ? "R3" : "R2", "epc", epc, m_epc);
    chk("R8", "error_epc", eepc, m_eepc);
    chk("R9", "depc", depc, m_depc);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; valid = 1'b0; kind = 0; code = 0; pc = 0; ds = 0;
    status = 0; cause = 0; dbg = 0; ebase = 0; refill = 0; dmode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset taken", {31'd0, taken}, 32'd0);
    chk("R1", "reset next_pc", npc, 32'd0);
    chk("R1", "reset epc", epc, 32'd0);
    chk("R1", "reset status", st_o, 32'd0);

    // R2: delay slot general fault, EXL clear, BEV clear
    fire(4'd0, 5'd4, 32'h8000_1004, 1'b1, 32'h0, 32'h0, 32'h0, 32'h8001_23FF, 1'b0, 1'b0);
    // R3: EXL set keeps EPC and BD
    fire(4'd0, 5'd12, 32'h0040_0000, 1'b1, 32'h2, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b0);
    // R6: refill with EXL clear, then with EXL set
    fire(4'd1, 5'd2, 32'h0040_0100, 1'b0, 32'h0, 32'h0, 32'h0, 32'h8000_0000, 1'b1, 1'b0);
    fire(4'd1, 5'd2, 32'h0040_0200, 1'b0, 32'h2, 32'h0, 32'h0, 32'h8000_0000, 1'b1, 1'b0);
    // R5: BEV set base
    fire(4'd0, 5'd10, 32'h0040_0300, 1'b0, 32'h0040_0000, 32'h0, 32'h0, 32'h1234_5678, 1'b0, 1'b0);
    // R7: interrupt with IV set
    fire(4'd2, 5'd0, 32'h0040_0400, 1'b0, 32'h0, 32'h0080_0000, 32'h0, 32'h9000_0000, 1'b0, 1'b0);
    // R8: soft reset in delay slot, NMI with EXL set
    fire(4'd4, 5'd0, 32'hBFC0_1000, 1'b1, 32'h0, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b0);
    fire(4'd5, 5'd0, 32'hBFC0_2000, 1'b0, 32'h2, 32'h8000_0000, 32'h0, 32'h0, 1'b0, 1'b0);
    // R9: single step in delay slot saves plain PC
    fire(4'd6, 5'd0, 32'h0040_0500, 1'b1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
    // R10: interrupt in debug mode
    fire(4'd2, 5'd0, 32'h0040_0600, 1'b1, 32'h0, 32'h0080_0000, 32'h0, 32'h0, 1'b0, 1'b1);

    // R1: outputs hold while idle
    @(negedge clk);
    chk("R1", "idle taken", {31'd0, taken}, 32'd0);
    chk("R1", "idle depc", depc, m_depc);

    for (int i = 0; i < 400; i++) begin
      fire(4'($urandom % 12), 5'($urandom), $urandom, 1'($urandom), $urandom,
           $urandom, $urandom, $urandom, 1'($urandom), 1'($urandom));
      if ($urandom % 4 == 0) begin
        @(negedge clk);
        chk("R1", "idle taken", {31'd0, taken}, 32'd0);
        chk("R1", "idle epc", epc, m_epc);
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule